// File: doc/BRIEF.md
# Sizable Base Address Register

This block is one base address register in the configuration header of a peripheral endpoint. Host software learns how much address space the endpoint wants by writing all ones and reading the register back. Every address bit below the decode size reads back as zero, so the readback is a mask from which software derives the size. Software then writes the chosen base address. From then on the block compares each incoming transaction address against that base and raises a hit when the transaction falls inside the window.

A parameter picks the variant. A memory-space register has a hard-wired low field of zero. An I/O-space register has its lowest bit hard-wired to one. The decode size is a power of two set by a parameter, and the window is always aligned to that size. The hit only fires when the command-register enable that belongs to the register's space is set. The configuration port is 32 bits wide and has per-byte write enables. The readback is combinational from the stored base. A write takes effect at the clock edge that samples it.

Top module: `bar_window_reg`

## Requirements
- R1: After reset the stored base is zero. `cfg_rdata` reads 0x00000000 for a memory register and 0x00000001 for an I/O register.
- R2: Bit 0 of `cfg_rdata` always equals the space type (0 = memory, 1 = I/O), and no write changes it.
- R3: For a memory register, bits 3:1 always read zero. For an I/O register, bit 1 always reads zero. Writes to these bits are ignored.
- R4: After a write of 0xFFFFFFFF with all four byte enables set, `cfg_rdata` equals ~(2^SIZE_LOG2 - 1) with the bit 0 type value ORed in. Every bit below SIZE_LOG2 other than bit 0 reads zero.
- R5: `cfg_be[i]` gates byte lane i (bits 8i+7:8i). A write leaves the lanes whose enable is low unchanged. With `cfg_wr` low, `cfg_rdata` holds.
- R6: With the enable and space conditions met, `hit` is high exactly when `txn_addr` bits above SIZE_LOG2-1 equal the stored base bits. Address bits below the size boundary are ignored.
- R7: `hit` stays low while the space enable is clear: `cmd_mem_en` for a memory register, `cmd_io_en` for an I/O register. The other enable has no effect.
- R8: `hit` stays low when `txn_valid` is low or when `txn_is_io` differs from the register's space type.
- R9: A write changes `cfg_rdata` and the decoded window only from the clock edge that samples `cfg_wr`. In the cycle before that edge, the old value still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Register readback (base plus fixed low bits) |
| cmd_mem_en | input | 1 | Command-register memory-space enable |
| cmd_io_en | input | 1 | Command-register I/O-space enable |
| txn_valid | input | 1 | Incoming transaction address is valid |
| txn_is_io | input | 1 | Incoming transaction targets I/O space |
| txn_addr | input | 32 | Incoming transaction address |
| hit | output | 1 | Transaction falls inside the programmed window |

## Verification
The bench builds two copies of the block side by side.

The first is a memory register with SIZE_LOG2 = 8, a 256-byte window. It has a wide masked field that crosses the first byte lane, so a partial byte write and the window's upper and lower edges can be probed.

The second is an I/O register with SIZE_LOG2 = 2, the smallest legal size. In this copy the writable field begins directly above the read-only bit 1 and the type bit. The two copies share the transaction and enable inputs, so one transaction checks space-type rejection in one copy and a hit in the other at the same time.

// File: rtl/bar_pkg.sv
package bar_pkg;

  localparam int unsigned CFG_W   = 32;
  localparam int unsigned LANES   = CFG_W / 8;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  // Writable address bits: everything at or above the size boundary.
  function automatic logic [CFG_W-1:0] size_mask(input int unsigned lg);
    logic [CFG_W-1:0] one;
    one = {{(CFG_W-1){1'b0}}, 1'b1};
    return ~((one << lg) - one);
  endfunction

  // Hard-wired low field returned on every read.
  function automatic logic [CFG_W-1:0] fixed_bits(input logic is_io);
    return is_io ? {{(CFG_W-1){1'b0}}, 1'b1} : '0;
  endfunction

  // Bits that must always read zero (read-only beyond the type bit).
  function automatic logic [CFG_W-1:0] ro_zero_bits(input logic is_io);
    return is_io ? 32'h0000_0002 : 32'h0000_000E;
  endfunction

  function automatic int unsigned min_size_log2(input logic is_io);
    return is_io ? 2 : 4;
  endfunction

endpackage

// File: rtl/bar_store.sv
module bar_store
  import bar_pkg::*;
#(
  parameter logic [CFG_W-1:0] WR_MASK = 32'hFFFF_FF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [7:0] LANE_MASK = WR_MASK[g*8 +: 8];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= 8'h00;
      end else if (wr && be[g]) begin
        lane_q <= wdata[g*8 +: 8] & LANE_MASK;
      end
    end

    assign q[g*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/bar_space_sel.sv
module bar_space_sel
  import bar_pkg::*;
#(
  parameter bit IS_IO = 1'b0
) (
  input  logic cmd_mem_en,
  input  logic cmd_io_en,
  input  logic txn_is_io,
  output logic space_en,
  output logic space_ok
);

  localparam space_e MY_SPACE = IS_IO ? SPACE_IO : SPACE_MEM;

  always_comb begin
    space_en = (MY_SPACE == SPACE_IO) ? cmd_io_en : cmd_mem_en;
    space_ok = (space_e'(txn_is_io) == MY_SPACE);
  end

endmodule

// File: rtl/bar_decode.sv
module bar_decode
  import bar_pkg::*;
#(
  parameter logic [CFG_W-1:0] CMP_MASK = 32'hFFFF_FF00
) (
  input  logic [CFG_W-1:0] base,
  input  logic [CFG_W-1:0] txn_addr,
  input  logic             txn_valid,
  input  logic             space_ok,
  input  logic             space_en,
  output logic             base_match,
  output logic             hit
);

  logic [CFG_W-1:0] diff;

  always_comb begin
    diff       = (txn_addr ^ base) & CMP_MASK;
    base_match = (diff == '0);
    hit        = txn_valid && space_ok && space_en && base_match;
  end

endmodule

// File: rtl/bar_window_reg.sv
module bar_window_reg
  import bar_pkg::*;
#(
  parameter bit          IS_IO     = 1'b0,
  parameter int unsigned SIZE_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cmd_mem_en,
  input  logic        cmd_io_en,
  input  logic        txn_valid,
  input  logic        txn_is_io,
  input  logic [31:0] txn_addr,
  output logic        hit
);

  localparam logic [CFG_W-1:0] WR_MASK  = size_mask(SIZE_LOG2);
  localparam logic [CFG_W-1:0] FIXED    = fixed_bits(IS_IO);

  if (SIZE_LOG2 < min_size_log2(IS_IO) || SIZE_LOG2 > 31) begin : g_bad_size
    $error("bar_window_reg: SIZE_LOG2 out of range for this space type");
  end

  logic [CFG_W-1:0] base_q;
  logic             space_en;
  logic             space_ok;
  logic             base_match;

  bar_store #(.WR_MASK(WR_MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .q     (base_q)
  );

  bar_space_sel #(.IS_IO(IS_IO)) u_space (
    .cmd_mem_en (cmd_mem_en),
    .cmd_io_en  (cmd_io_en),
    .txn_is_io  (txn_is_io),
    .space_en   (space_en),
    .space_ok   (space_ok)
  );

  bar_decode #(.CMP_MASK(WR_MASK)) u_dec (
    .base       (base_q),
    .txn_addr   (txn_addr),
    .txn_valid  (txn_valid),
    .space_ok   (space_ok),
    .space_en   (space_en),
    .base_match (base_match),
    .hit        (hit)
  );

  assign cfg_rdata = base_q | FIXED;

endmodule

// File: rtl/bar_window_chk.sv
module bar_window_chk
  import bar_pkg::*;
#(
  parameter bit          IS_IO     = 1'b0,
  parameter int unsigned SIZE_LOG2 = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        txn_valid,
  input logic        txn_is_io,
  input logic        space_en,
  input logic        base_match,
  input logic        hit
);

  localparam logic [31:0] FIX   = fixed_bits(IS_IO);
  localparam logic [31:0] PROBE = size_mask(SIZE_LOG2) | FIX;
  localparam logic [31:0] ROZ   = ro_zero_bits(IS_IO);

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_rdata == FIX);

  p_type_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] == IS_IO);

  p_ro_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ROZ) == 32'h0);

  p_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 4'hF && cfg_wdata == 32'hFFFF_FFFF) |=> cfg_rdata == PROBE);

  p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_be[3]) |=> cfg_rdata[31:24] == $past(cfg_rdata[31:24]));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> base_match);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !space_en |-> !hit);

  p_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (txn_valid && txn_is_io == IS_IO));

endmodule

bind bar_window_reg bar_window_chk #(.IS_IO(IS_IO), .SIZE_LOG2(SIZE_LOG2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_be     (cfg_be),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .txn_valid  (txn_valid),
  .txn_is_io  (txn_is_io),
  .space_en   (space_en),
  .base_match (base_match),
  .hit        (hit)
);

// File: tb/sim_bar_window_reg.sv
module sim_bar_window_reg;

  localparam longint SZ0 = 256;  // memory copy, SIZE_LOG2 = 8
  localparam longint SZ1 = 4;    // I/O copy, SIZE_LOG2 = 2

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic        mem_en = 1'b0, io_en = 1'b0;
  logic        tv = 1'b0, tio = 1'b0;
  logic [31:0] taddr = '0;
  logic [31:0] rd0, rd1;
  logic        hit0, hit1;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bar_window_reg #(.IS_IO(1'b0), .SIZE_LOG2(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr0), .cfg_be(be), .cfg_wdata(wdata),
    .cfg_rdata(rd0), .cmd_mem_en(mem_en), .cmd_io_en(io_en),
    .txn_valid(tv), .txn_is_io(tio), .txn_addr(taddr), .hit(hit0));

  bar_window_reg #(.IS_IO(1'b1), .SIZE_LOG2(2)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr1), .cfg_be(be), .cfg_wdata(wdata),
    .cfg_rdata(rd1), .cmd_mem_en(mem_en), .cmd_io_en(io_en),
    .txn_valid(tv), .txn_is_io(tio), .txn_addr(taddr), .hit(hit1));

  // Behavioural reference: base kept as an integer, rounded down to the size.
  longint m0 = 0, m1 = 0;

  function automatic longint apply_wr(longint old, logic [31:0] d, logic [3:0] e, longint sz);
    longint v = old;
    for (int i = 0; i < 4; i++) begin
      if (e[i]) begin
        longint unit = longint'(1) << (8 * i);
        v = v - ((v / unit) % 256) * unit + longint'(d[8*i +: 8]) * unit;
      end
    end
    return v - (v % sz);
  endfunction

  function automatic bit exp_hit(longint m, longint sz, bit inst_io, bit en);
    return tv && (tio == inst_io) && en && ((longint'(taddr) / sz) == (m / sz));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = 0;
      m1 = 0;
    end else begin
      if (wr0) m0 = apply_wr(m0, wdata, be, SZ0);
      if (wr1) m1 = apply_wr(m1, wdata, be, SZ1);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rd0 model", rd0, 32'(m0));
      chk("R2 rd1 model", rd1, 32'(m1) | 32'h1);
      chk("R6 hit0 model", {31'b0, hit0}, {31'b0, exp_hit(m0, SZ0, 1'b0, mem_en)});
      chk("R6 hit1 model", {31'b0, hit1}, {31'b0, exp_hit(m1, SZ1, 1'b1, io_en)});
    end
  end

  task automatic do_write(input bit which, input logic [31:0] d, input logic [3:0] e);
    @(negedge clk); #1;
    wr0 = !which; wr1 = which; wdata = d; be = e;
    @(negedge clk); #1;
    wr0 = 1'b0; wr1 = 1'b0; be = 4'h0;
  endtask

  task automatic probe(input bit io, input logic [31:0] a, input bit v);
    @(negedge clk); #1;
    tio = io; taddr = a; tv = v;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 mem reset", rd0, 32'h0000_0000);
    chk("R1 io reset", rd1, 32'h0000_0001);

    // Size probe
    do_write(1'b0, 32'hFFFF_FFFF, 4'hF);
    do_write(1'b1, 32'hFFFF_FFFF, 4'hF);
    chk("R4 mem probe", rd0, 32'hFFFF_FF00);
    chk("R4 io probe", rd1, 32'hFFFF_FFFD);

    // Type bit and read-only low bits
    do_write(1'b0, 32'h0000_000F, 4'hF);
    chk("R2 R3 mem low bits", rd0, 32'h0000_0000);
    do_write(1'b1, 32'h0000_0002, 4'hF);
    chk("R2 R3 io low bits", rd1, 32'h0000_0001);

    // Byte lanes
    do_write(1'b0, 32'h1234_5678, 4'hF);
    chk("R5 mem full", rd0, 32'h1234_5600);
    do_write(1'b0, 32'hFFFF_FFFF, 4'b0100);
    chk("R5 mem lane2", rd0, 32'h12FF_5600);
    do_write(1'b1, 32'hAAAA_AAAB, 4'b0001);
    chk("R5 io lane0", rd1, 32'h0000_00A9);

    // Write timing
    @(negedge clk); #1;
    wr0 = 1'b1; wdata = 32'hA000_0000; be = 4'hF;
    #1 chk("R9 old value before edge", rd0, 32'h12FF_5600);
    @(negedge clk); #1;
    wr0 = 1'b0; be = 4'h0;
    chk("R9 new value after edge", rd0, 32'hA000_0000);
    do_write(1'b1, 32'h0000_1234, 4'hF);
    chk("R5 io base", rd1, 32'h0000_1235);

    // Enable gating
    probe(1'b0, 32'hA000_0010, 1'b1);
    chk("R7 mem disabled", {31'b0, hit0}, 32'h0);
    io_en = 1'b1;
    #1 chk("R7 wrong enable", {31'b0, hit0}, 32'h0);
    mem_en = 1'b1;
    #1 chk("R6 mem inside", {31'b0, hit0}, 32'h1);

    // Window edges
    probe(1'b0, 32'hA000_00FF, 1'b1);
    chk("R6 mem top edge", {31'b0, hit0}, 32'h1);
    probe(1'b0, 32'hA000_0100, 1'b1);
    chk("R6 mem above", {31'b0, hit0}, 32'h0);
    probe(1'b0, 32'h9FFF_FFFF, 1'b1);
    chk("R6 mem below", {31'b0, hit0}, 32'h0);

    // Space type and valid
    probe(1'b1, 32'hA000_0010, 1'b1);
    chk("R8 mem io txn", {31'b0, hit0}, 32'h0);
    probe(1'b0, 32'hA000_0010, 1'b0);
    chk("R8 mem invalid", {31'b0, hit0}, 32'h0);

    // I/O window, minimum size
    probe(1'b1, 32'h0000_1237, 1'b1);
    chk("R6 io inside", {31'b0, hit1}, 32'h1);
    chk("R8 mem skips io txn", {31'b0, hit0}, 32'h0);
    probe(1'b1, 32'h0000_1238, 1'b1);
    chk("R6 io above", {31'b0, hit1}, 32'h0);
    probe(1'b0, 32'h0000_1234, 1'b1);
    chk("R8 io mem txn", {31'b0, hit1}, 32'h0);
    probe(1'b1, 32'h0000_1234, 1'b1);
    io_en = 1'b0;
    #1 chk("R7 io disabled", {31'b0, hit1}, 32'h0);

    // Reset clears the base again
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    chk("R1 mem after reset", rd0, 32'h0000_0000);
    chk("R1 io after reset", rd1, 32'h0000_0001);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule